// File: doc/BRIEF.md
# Synchronous FIFO with Reset-Aware Status Flags

This block is a single-clock first-in first-out buffer whose main concern is a complete, predictable set of status outputs. Alongside the data path it reports:

- occupancy (full, one-slot-left, programmable high mark; empty, one-word-left, programmable low mark);
- handshakes for accepted writes and reads;
- per-cycle reports of rejected accesses;
- the current word count, on both a write-side and a read-side output.

It suits any place where a producer and a consumer share a clock and need flow-control flags they can register directly.

Reset is synchronous and active low. While reset is held, the storage pointers and the count are cleared and every output takes a fixed value. The value of the full-type flags during reset is a build parameter. When that value is 1, the flags also block writes in the first cycle after release, and they settle to the true occupancy at the next edge. The data output takes a parameter-defined reset word. Every output register carries a power-up value, so the outputs are defined before the first clock edge.

All outputs are registered. The result of any access appears one clock edge after the edge that samples it.

Top module: `fsf_top`

## Requirements
- R1: While rst_n is low, full, almost_full and prog_full equal the FULL_RST parameter. In the first cycle after release they still show that value, and they take the value given by occupancy from the following edge on.
- R2: While rst_n is low, empty, almost_empty and prog_empty are 1.
- R3: While rst_n is low, data_valid, wr_ack, overflow and underflow are 0, both data counts are 0, and the buffer is emptied, so that after release the first read word is the first word written after reset.
- R4: While rst_n is low, dout equals the DOUT_RST parameter, whose default is 0.
- R5: Before the first clock edge, full, almost_full and prog_full are 0, empty, almost_empty and prog_empty are 1, data_valid, wr_ack, overflow, underflow and both counts are 0, and dout equals DOUT_RST.
- R6: A write is accepted when wr_en is 1 and full is 0 at a clock edge. wr_ack is then 1 for the cycle after that edge.
- R7: When wr_en is 1 and full is 1 at an edge, overflow is 1 for the next cycle and wr_ack is 0. Neither the contents nor the count change.
- R8: When rd_en is 1 and empty is 1 at an edge, underflow is 1 for the next cycle and data_valid stays 0.
- R9: A read is accepted when rd_en is 1 and empty is 0. In the next cycle, dout holds the oldest stored word and data_valid is 1. When no read is accepted, dout holds its value.
- R10: After each edge, both counts equal the number of stored words, full is 1 exactly at DEPTH words, and empty is 1 exactly at 0 words. An accepted read and an accepted write at the same edge leave the count unchanged.
- R11: almost_full is 1 when the count is DEPTH-1 or more. almost_empty is 1 when the count is 1 or less.
- R12: prog_full is 1 when the count is PF_THRESH or more. prog_empty is 1 when the count is PE_THRESH or less.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write request |
| din | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| dout | output | WIDTH | Read data, updated on accepted reads |
| full | output | 1 | Buffer holds DEPTH words |
| almost_full | output | 1 | At most one free slot |
| prog_full | output | 1 | Count at or above PF_THRESH |
| empty | output | 1 | Buffer holds no words |
| almost_empty | output | 1 | At most one stored word |
| prog_empty | output | 1 | Count at or below PE_THRESH |
| data_valid | output | 1 | dout carries a freshly read word |
| wr_ack | output | 1 | Previous-edge write was accepted |
| overflow | output | 1 | Previous-edge write was rejected |
| underflow | output | 1 | Previous-edge read was rejected |
| wr_data_count | output | CNT_W | Stored word count, write side |
| rd_data_count | output | CNT_W | Stored word count, read side |

## Verification
Every output is due exactly one edge after the inputs that cause it. This includes the reset values, the release of the full-type flags, and the rejection reports. Inputs are driven on the falling edge. Each output is compared at the next falling edge against a bench model that is stepped once per drive.

The acceptance rule in the model uses the previously expected full and empty values. As a result, the extra blocked cycle after reset and the full-and-read-together case are predicted at the same edge at which the design resolves them.

// File: rtl/fsf_pkg.sv
// Package: shared types for the FIFO status block.
// Assumes: nothing beyond IEEE 1800-2017.
package fsf_pkg;

    // Bundle of the six level-type status flags.
    typedef struct packed {
        logic full;
        logic almost_full;
        logic prog_full;
        logic empty;
        logic almost_empty;
        logic prog_empty;
    } fsf_flags_t;

endpackage

// File: rtl/fsf_ctrl.sv
// Module: access control and storage pointers.
// Decides which requests are accepted, from the registered full and empty flags.
// Keeps the read pointer, the write pointer and the word count, and registers the
// per-access reports.
// Assumes: DEPTH >= 4. full and empty come from fsf_flags in the same clock domain.
module fsf_ctrl #(
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1),
    parameter int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              full,
    input  logic              empty,
    output logic              wr_acc,
    output logic              rd_acc,
    output logic [ADDR_W-1:0] wptr,
    output logic [ADDR_W-1:0] rptr,
    output logic [CNT_W-1:0]  cnt_next,
    output logic              wr_ack,
    output logic              data_valid,
    output logic              overflow,
    output logic              underflow
);

    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);

    logic [ADDR_W-1:0] wptr_q = '0;
    logic [ADDR_W-1:0] rptr_q = '0;
    logic [CNT_W-1:0]  cnt_q  = '0;
    logic              ack_q  = 1'b0;
    logic              dv_q   = 1'b0;
    logic              ovf_q  = 1'b0;
    logic              udf_q  = 1'b0;

    // Acceptance: a request passes only when its blocking flag is low and reset is released.
    always_comb begin
        wr_acc = rst_n && wr_en && !full;
        rd_acc = rst_n && rd_en && !empty;
    end

    // Next occupancy after this edge's accepted accesses.
    always_comb begin
        cnt_next = cnt_q;
        if (!rst_n) begin
            cnt_next = '0;
        end else if (wr_acc && !rd_acc) begin
            cnt_next = cnt_q + CNT_W'(1);
        end else if (rd_acc && !wr_acc) begin
            cnt_next = cnt_q - CNT_W'(1);
        end
    end

    // Pointer and count registers, with wrap-around at DEPTH.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (wr_acc) wptr_q <= (wptr_q == LAST_ADDR) ? '0 : wptr_q + ADDR_W'(1);
            if (rd_acc) rptr_q <= (rptr_q == LAST_ADDR) ? '0 : rptr_q + ADDR_W'(1);
        end
        cnt_q <= cnt_next;
    end

    // Per-access reports, registered one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            dv_q  <= 1'b0;
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            ack_q <= wr_acc;
            dv_q  <= rd_acc;
            ovf_q <= wr_en && full;
            udf_q <= rd_en && empty;
        end
    end

    assign wptr       = wptr_q;
    assign rptr       = rptr_q;
    assign wr_ack     = ack_q;
    assign data_valid = dv_q;
    assign overflow   = ovf_q;
    assign underflow  = udf_q;

endmodule

// File: rtl/fsf_store.sv
// Module: word storage and the registered read-data output.
// Assumes: wr_acc and rd_acc are never both aimed at a word that is read in the
// same cycle it is written. The control logic guarantees this, because the two
// pointers are equal only when the buffer is empty or full.
module fsf_store #(
    parameter int                WIDTH    = 8,
    parameter int                DEPTH    = 16,
    parameter int                ADDR_W   = $clog2(DEPTH),
    parameter logic [WIDTH-1:0]  DOUT_RST = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_acc,
    input  logic [ADDR_W-1:0] wptr,
    input  logic [WIDTH-1:0]  din,
    input  logic              rd_acc,
    input  logic [ADDR_W-1:0] rptr,
    output logic [WIDTH-1:0]  dout
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [WIDTH-1:0] dout_q = DOUT_RST;

    // Storage write port. The contents need no reset, because the pointers define validity.
    always_ff @(posedge clk) begin
        if (wr_acc) mem[wptr] <= din;
    end

    // Read register: the reset word, a newly read word, or the held value.
    always_ff @(posedge clk) begin
        if (!rst_n)      dout_q <= DOUT_RST;
        else if (rd_acc) dout_q <= mem[rptr];
    end

    assign dout = dout_q;

endmodule

// File: rtl/fsf_flags.sv
// Module: registered status flags and word counts.
// Computes each flag from the next occupancy, so that flags and counts change at the same edge.
// Assumes: 1 <= PE_THRESH < PF_THRESH <= DEPTH.
module fsf_flags
    import fsf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int CNT_W     = $clog2(DEPTH + 1),
    parameter int PF_THRESH = 12,
    parameter int PE_THRESH = 3,
    parameter bit FULL_RST  = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_next,
    output fsf_flags_t       flags,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] AF_CNT   = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] PF_CNT   = CNT_W'(PF_THRESH);
    localparam logic [CNT_W-1:0] PE_CNT   = CNT_W'(PE_THRESH);
    localparam logic [CNT_W-1:0] AE_CNT   = CNT_W'(1);

    logic             full_q = 1'b0;
    logic             af_q   = 1'b0;
    logic             pf_q   = 1'b0;
    logic             empty_q = 1'b1;
    logic             ae_q   = 1'b1;
    logic             pe_q   = 1'b1;
    logic [CNT_W-1:0] cnt_q  = '0;

    // Full-type flags: the parameterised value in reset, otherwise upper thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full_q <= FULL_RST;
            af_q   <= FULL_RST;
            pf_q   <= FULL_RST;
        end else begin
            full_q <= (cnt_next == FULL_CNT);
            af_q   <= (cnt_next >= AF_CNT);
            pf_q   <= (cnt_next >= PF_CNT);
        end
    end

    // Empty-type flags: set in reset, otherwise lower thresholds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            empty_q <= 1'b1;
            ae_q    <= 1'b1;
            pe_q    <= 1'b1;
        end else begin
            empty_q <= (cnt_next == '0);
            ae_q    <= (cnt_next <= AE_CNT);
            pe_q    <= (cnt_next <= PE_CNT);
        end
    end

    // Published count, cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end

    always_comb begin
        flags.full         = full_q;
        flags.almost_full  = af_q;
        flags.prog_full    = pf_q;
        flags.empty        = empty_q;
        flags.almost_empty = ae_q;
        flags.prog_empty   = pe_q;
    end

    assign count = cnt_q;

endmodule

// File: rtl/fsf_top.sv
// Module: top level of the synchronous FIFO with reset-aware status flags.
// Connects access control, storage and flag generation.
// Assumes: a single clock, a synchronous active-low reset, DEPTH >= 4 and the
// threshold ordering stated in fsf_flags.
module fsf_top
    import fsf_pkg::*;
#(
    parameter int                WIDTH     = 8,
    parameter int                DEPTH     = 16,
    parameter int                PF_THRESH = 12,
    parameter int                PE_THRESH = 3,
    parameter bit                FULL_RST  = 1'b1,
    parameter logic [WIDTH-1:0]  DOUT_RST  = '0,
    localparam int               CNT_W     = $clog2(DEPTH + 1),
    localparam int               ADDR_W    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] din,
    input  logic             rd_en,
    output logic [WIDTH-1:0] dout,
    output logic             full,
    output logic             almost_full,
    output logic             prog_full,
    output logic             empty,
    output logic             almost_empty,
    output logic             prog_empty,
    output logic             data_valid,
    output logic             wr_ack,
    output logic             overflow,
    output logic             underflow,
    output logic [CNT_W-1:0] wr_data_count,
    output logic [CNT_W-1:0] rd_data_count
);

    logic              wr_acc;
    logic              rd_acc;
    logic [ADDR_W-1:0] wptr;
    logic [ADDR_W-1:0] rptr;
    logic [CNT_W-1:0]  cnt_next;
    logic [CNT_W-1:0]  count;
    fsf_flags_t        flags;

    fsf_ctrl #(
        .DEPTH (DEPTH),
        .CNT_W (CNT_W),
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .full      (flags.full),
        .empty     (flags.empty),
        .wr_acc    (wr_acc),
        .rd_acc    (rd_acc),
        .wptr      (wptr),
        .rptr      (rptr),
        .cnt_next  (cnt_next),
        .wr_ack    (wr_ack),
        .data_valid(data_valid),
        .overflow  (overflow),
        .underflow (underflow)
    );

    fsf_store #(
        .WIDTH   (WIDTH),
        .DEPTH   (DEPTH),
        .ADDR_W  (ADDR_W),
        .DOUT_RST(DOUT_RST)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_acc(wr_acc),
        .wptr  (wptr),
        .din   (din),
        .rd_acc(rd_acc),
        .rptr  (rptr),
        .dout  (dout)
    );

    fsf_flags #(
        .DEPTH    (DEPTH),
        .CNT_W    (CNT_W),
        .PF_THRESH(PF_THRESH),
        .PE_THRESH(PE_THRESH),
        .FULL_RST (FULL_RST)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_next(cnt_next),
        .flags   (flags),
        .count   (count)
    );

    // Port mapping of the flag bundle and the two count views.
    always_comb begin
        full          = flags.full;
        almost_full   = flags.almost_full;
        prog_full     = flags.prog_full;
        empty         = flags.empty;
        almost_empty  = flags.almost_empty;
        prog_empty    = flags.prog_empty;
        wr_data_count = count;
        rd_data_count = count;
    end

endmodule

// File: rtl/fsf_checker.sv
// Module: property checker for fsf_top, attached by bind below.
// Assumes: it samples the top-level ports only.
module fsf_checker #(
    parameter int DEPTH    = 16,
    parameter int WIDTH    = 8,
    parameter int CNT_W    = $clog2(DEPTH + 1),
    parameter bit FULL_RST = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             rd_en,
    input logic [WIDTH-1:0] dout,
    input logic             full,
    input logic             empty,
    input logic             data_valid,
    input logic             wr_ack,
    input logic             overflow,
    input logic             underflow,
    input logic [CNT_W-1:0] wr_data_count
);

    // R1
    rst_full_val_chk: assert property (@(posedge clk)
        !rst_n |=> (full == FULL_RST));

    // R3
    rst_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!data_valid && !wr_ack && !overflow && !underflow && wr_data_count == '0));

    // R2
    rst_empty_chk: assert property (@(posedge clk)
        !rst_n |=> empty);

    // R7
    ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |-> ($past(wr_en) && $past(full) && !wr_ack));

    // R8
    udf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underflow |-> ($past(rd_en) && $past(empty) && !data_valid));

    // R10
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (wr_data_count ==
            $past(wr_data_count) + {{(CNT_W-1){1'b0}}, wr_ack} - {{(CNT_W-1){1'b0}}, data_valid}));

    // R10
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> !(full && empty));

    // R9
    dout_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !data_valid) |-> $stable(dout));

endmodule

bind fsf_top fsf_checker #(
    .DEPTH   (DEPTH),
    .WIDTH   (WIDTH),
    .CNT_W   (CNT_W),
    .FULL_RST(FULL_RST)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .dout         (dout),
    .full         (full),
    .empty        (empty),
    .data_valid   (data_valid),
    .wr_ack       (wr_ack),
    .overflow     (overflow),
    .underflow    (underflow),
    .wr_data_count(wr_data_count)
);

// File: tb/fsf_top_tb.sv
`timescale 1ns/1ps
module fsf_top_tb;

    localparam int              WIDTH     = 8;
    localparam int              DEPTH     = 8;
    localparam int              PF_THRESH = 6;
    localparam int              PE_THRESH = 2;
    localparam bit              FULL_RST  = 1'b1;
    localparam logic [7:0]      DOUT_RST  = 8'h5A;
    localparam int              CNT_W     = $clog2(DEPTH + 1);

    logic             clk   = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [WIDTH-1:0] din   = '0;
    logic [WIDTH-1:0] dout;
    logic             full, almost_full, prog_full;
    logic             empty, almost_empty, prog_empty;
    logic             data_valid, wr_ack, overflow, underflow;
    logic [CNT_W-1:0] wr_data_count, rd_data_count;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    // Model state: the expected outputs after the next edge.
    int q[$];
    int e_dout;
    bit e_full, e_af, e_pf, e_empty, e_ae, e_pe, e_dv, e_ack, e_ovf, e_udf;
    int e_cnt;
    int phase;  // 0 normal, 1 result of a reset edge, 2 first edge after release

    fsf_top #(
        .WIDTH    (WIDTH),
        .DEPTH    (DEPTH),
        .PF_THRESH(PF_THRESH),
        .PE_THRESH(PE_THRESH),
        .FULL_RST (FULL_RST),
        .DOUT_RST (DOUT_RST)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .din          (din),
        .rd_en        (rd_en),
        .dout         (dout),
        .full         (full),
        .almost_full  (almost_full),
        .prog_full    (prog_full),
        .empty        (empty),
        .almost_empty (almost_empty),
        .prog_empty   (prog_empty),
        .data_valid   (data_valid),
        .wr_ack       (wr_ack),
        .overflow     (overflow),
        .underflow    (underflow),
        .wr_data_count(wr_data_count),
        .rd_data_count(rd_data_count)
    );

    always #2 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Flags from a word count, as the requirements define them.
    function automatic void flags_from(input int n);
        e_full  = (n == DEPTH);
        e_af    = (n >= DEPTH - 1);
        e_pf    = (n >= PF_THRESH);
        e_empty = (n == 0);
        e_ae    = (n <= 1);
        e_pe    = (n <= PE_THRESH);
        e_cnt   = n;
    endfunction

    function automatic void model_reset();
        q.delete();
        e_full = FULL_RST; e_af = FULL_RST; e_pf = FULL_RST;
        e_empty = 1; e_ae = 1; e_pe = 1;
        e_dv = 0; e_ack = 0; e_ovf = 0; e_udf = 0; e_cnt = 0;
        e_dout = DOUT_RST;
        phase = 1;
    endfunction

    // One edge of the model, using the currently expected flags for acceptance.
    function automatic void model_step(input bit r, input bit we, input int d, input bit re);
        bit wa, ra;
        if (!r) begin
            model_reset();
            return;
        end
        wa    = we && !e_full;
        ra    = re && !e_empty;
        e_ovf = we && e_full;
        e_udf = re && e_empty;
        e_ack = wa;
        e_dv  = ra;
        if (ra) e_dout = q.pop_front();
        if (wa) q.push_back(d);
        flags_from(q.size());
        phase = (phase == 1) ? 2 : 0;
    endfunction

    task automatic compare_all();
        string tf, te, tz, td;
        tf = (phase == 1 || phase == 2) ? "R1" : "R10";
        te = (phase == 1) ? "R2" : "R10";
        tz = (phase == 1) ? "R3" : "R10";
        td = (phase == 1) ? "R4" : "R9";
        chk(tf, "full", full, e_full);
        chk((phase != 0) ? "R1" : "R11", "almost_full", almost_full, e_af);
        chk((phase != 0) ? "R1" : "R12", "prog_full", prog_full, e_pf);
        chk(te, "empty", empty, e_empty);
        chk((phase == 1) ? "R2" : "R11", "almost_empty", almost_empty, e_ae);
        chk((phase == 1) ? "R2" : "R12", "prog_empty", prog_empty, e_pe);
        chk(tz, "wr_data_count", wr_data_count, e_cnt);
        chk(tz, "rd_data_count", rd_data_count, e_cnt);
        chk((phase == 1) ? "R3" : "R6", "wr_ack", wr_ack, e_ack);
        chk((phase == 1) ? "R3" : "R7", "overflow", overflow, e_ovf);
        chk((phase == 1) ? "R3" : "R8", "underflow", underflow, e_udf);
        chk((phase == 1) ? "R3" : "R9", "data_valid", data_valid, e_dv);
        chk(td, "dout", dout, e_dout);
    endtask

    task automatic step(input bit r, input bit we, input int d, input bit re);
        @(negedge clk);
        compare_all();
        rst_n = r;
        wr_en = we;
        din   = WIDTH'(d);
        rd_en = re;
        model_step(r, we, d, re);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R5: power-up values before the first edge
        #1;
        chk("R5", "full", full, 0);
        chk("R5", "almost_full", almost_full, 0);
        chk("R5", "prog_full", prog_full, 0);
        chk("R5", "empty", empty, 1);
        chk("R5", "almost_empty", almost_empty, 1);
        chk("R5", "prog_empty", prog_empty, 1);
        chk("R5", "data_valid", data_valid, 0);
        chk("R5", "wr_ack", wr_ack, 0);
        chk("R5", "overflow", overflow, 0);
        chk("R5", "underflow", underflow, 0);
        chk("R5", "wr_data_count", wr_data_count, 0);
        chk("R5", "dout", dout, DOUT_RST);

        // The first edge (t=2) samples reset, so the model starts from reset values.
        model_reset();
        step(0, 1, 8'h11, 1);   // requests during reset are ignored (R3)
        step(0, 0, 0, 0);
        // Release. At this edge full is still 1 (R1), so the write is rejected
        // as overflow (R7) and the read as underflow (R8).
        step(1, 1, 8'hAA, 1);
        // Fill to full, with one extra write that overflows (R6, R7, R10-R12).
        for (int i = 0; i < DEPTH + 1; i++) step(1, 1, 8'h20 + i, 0);
        // Full with read and write together: only the read is accepted (R7, R9).
        step(1, 1, 8'hEE, 1);
        // Drain past empty (R8, R9).
        for (int i = 0; i < DEPTH + 1; i++) step(1, 0, 0, 1);
        // Empty with both requests: the write is accepted and the read underflows.
        step(1, 1, 8'h77, 1);
        // Non-empty, non-full with both requests: the count holds (R10).
        step(1, 1, 8'h78, 1);
        step(1, 1, 8'h79, 0);
        step(1, 1, 8'h7A, 1);

        // Random traffic in phases with varying write and read bias.
        for (int p = 0; p < 6; p++) begin
            int wp, rp;
            wp = (p % 3 == 0) ? 80 : (p % 3 == 1) ? 20 : 50;
            rp = 100 - wp;
            for (int i = 0; i < 500; i++) begin
                step(1, ($urandom % 100) < wp, $urandom % 256, ($urandom % 100) < rp);
            end
            if (p == 2) begin
                // Reset in mid-run with the buffer partly full (R1-R4).
                step(0, 1, 8'h33, 1);
                step(1, 0, 0, 0);
                step(1, 1, 8'h44, 0);
                step(1, 0, 0, 1);   // the first word after reset comes out (R3)
            end
        end
        step(1, 0, 0, 0);
        @(negedge clk);
        compare_all();

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule